// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter, four bits wide by default, that can be preset from a parallel input and cleared by an active-low clear. The count advances on rising clock edges when both of its count enables are high and the load strobe is inactive. A low level on the active-low load strobe copies the preset word into the count register at the next edge instead.

A combinational carry output goes high while the count sits at its all-ones value and the carry-gating enable is high. The other count enable plays no part in the carry. Wider counters are built by feeding each stage's carry into the next stage's carry-gating enable, while every stage shares the plain enable. The carry path then acts as a look-ahead chain, and each stage steps exactly when all lower stages are at their maximum.

A build-time parameter chooses how the clear acts. In one variant it zeroes the register at once. In the other it takes effect at the next rising edge.

Top module: `presc_counter`

## Requirements
- R1: Clear has priority over load, and load has priority over counting. Clear and load asserted together give zero, and load with both enables high gives the preset value.
- R2: When load_n is low and clr_n is high at a rising edge, count takes the value of preset. Bit 0 is the least-significant bit in both vectors.
- R3: A low clr_n forces count to zero. With ASYNC_CLEAR=1 this happens without waiting for a clock edge. With ASYNC_CLEAR=0 the count holds until the next rising edge and is zero after it.
- R4: When clr_n, load_n, en_p and en_t are all high at a rising edge, count increases by one.
- R5: carry_out equals en_t ANDed with every bit of count. It is high only while count is all ones and en_t is high.
- R6: en_p has no effect on carry_out. A low en_t forces carry_out low at once and also stops counting.
- R7: When count is all ones and counting is enabled, the next edge wraps count to all zeros.
- R8: With clr_n and load_n high and en_p or en_t low, count holds its value across edges.
- R9: Stages cascade into a wider counter when each stage's en_t is driven by the previous stage's carry_out and en_p is shared. The chain then counts in binary across stage boundaries, including a full rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low synchronous preset load |
| en_p | input | 1 | Count enable that does not touch the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| preset | input | WIDTH | Parallel preset word, bit 0 least significant |
| count | output | WIDTH | Current count, bit 0 least significant |
| carry_out | output | 1 | High when count is all ones and en_t is high |

## Verification
The bench drives an asynchronous-clear instance and a synchronous-clear instance in parallel. Between edges it probes both while clr_n is low: a sync variant that cleared early, or an async variant that waited for the edge, would show a nonzero or early-zero count there.

Several inputs are asserted together to test priority. A design that let load beat clear would show the preset value. One that let counting beat load would show the old count plus one.

The carry is checked at all ones with en_p low and with en_t low. Gating the carry by en_p, or failing to gate it by en_t, would give a wrong carry level.

A three-stage chain is loaded just below stage boundaries and just below full rollover. A carry that lagged by a register, or a stage that ignored its en_t, would make the wide count skip or double-step.

// File: rtl/presc_pkg.sv
package presc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_INC   = 2'd3
    } presc_op_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic en_p;
        logic en_t;
    } presc_ctrl_t;

    // Priority: clear, then load, then increment, else hold.
    function automatic presc_op_e pick_op(presc_ctrl_t c);
        presc_op_e op;
        if (c.clr) begin
            op = OP_CLEAR;
        end else if (c.load) begin
            op = OP_LOAD;
        end else if (c.en_p && c.en_t) begin
            op = OP_INC;
        end else begin
            op = OP_HOLD;
        end
        return op;
    endfunction

endpackage

// File: rtl/presc_op_decode.sv
module presc_op_decode
    import presc_pkg::*;
(
    input  presc_ctrl_t ctrl,
    output presc_op_e   op
);
    always_comb begin
        op = pick_op(ctrl);
    end
endmodule

// File: rtl/presc_state_reg.sv
module presc_state_reg
    import presc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  presc_op_e        op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = preset;
            OP_INC:   nxt = count + ONE;
            default:  nxt = count;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    count <= ZERO;
                end else begin
                    count <= nxt;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                count <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/presc_carry_gen.sv
module presc_carry_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             en_t,
    output logic             carry
);
    logic [WIDTH:0] chain;

    assign chain[0] = en_t;
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_and
            assign chain[i+1] = chain[i] & count[i];
        end
    endgenerate
    assign carry = chain[WIDTH];
endmodule

// File: rtl/presc_counter.sv
module presc_counter
    import presc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    presc_ctrl_t ctrl;
    presc_op_e   op;

    always_comb begin
        ctrl.clr  = ~clr_n;
        ctrl.load = ~load_n;
        ctrl.en_p = en_p;
        ctrl.en_t = en_t;
    end

    presc_op_decode u_dec (
        .ctrl (ctrl),
        .op   (op)
    );

    presc_state_reg #(
        .WIDTH       (WIDTH),
        .ASYNC_CLEAR (ASYNC_CLEAR)
    ) u_reg (
        .clk    (clk),
        .clr_n  (clr_n),
        .op     (op),
        .preset (preset),
        .count  (count)
    );

    presc_carry_gen #(
        .WIDTH (WIDTH)
    ) u_carry (
        .count (count),
        .en_t  (en_t),
        .carry (carry_out)
    );
endmodule

// File: rtl/presc_counter_chk.sv
module presc_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    // The antecedent is the clear itself, so no disable is applied here.
    p_clear_r3: assert property (@(posedge clk)
        !clr_n |=> count == '0);

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(preset));

    p_load_over_count_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n && en_p && en_t) |=> count == $past(preset));

    p_increment_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && count != '1) |=> count == $past(count) + WIDTH'(1));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && count == '1) |=> count == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(count));

    p_carry_at_max_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (en_t && count == '1) |-> carry_out);

    p_carry_gated_r6: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !carry_out);

    always_comb begin
        if (carry_out) begin
            p_carry_only_max_r5: assert (en_t && (&count));
        end
    end
endmodule

bind presc_counter presc_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_p      (en_p),
    .en_t      (en_t),
    .preset    (preset),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/presc_counter_tb_top.sv
module presc_counter_tb_top;
    localparam int W      = 4;
    localparam int STAGES = 3;
    localparam int WW     = W * STAGES;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          clr_n   = 1'b0;
    logic          load_n  = 1'b1;
    logic          en_p    = 1'b0;
    logic          en_t    = 1'b0;
    logic [W-1:0]  preset  = '0;
    logic [WW-1:0] wpreset = '0;

    logic [W-1:0]      a_count, s_count;
    logic              a_carry, s_carry;
    logic [WW-1:0]     w_count;
    logic [STAGES-1:0] w_carry;
    logic [STAGES-1:0] w_ent;

    presc_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .preset(preset), .count(a_count), .carry_out(a_carry));

    presc_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) dut_s (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .preset(preset), .count(s_count), .carry_out(s_carry));

    // R9: cascade, each stage gated by the previous stage's carry.
    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_chain
            if (k == 0) begin : g_first
                assign w_ent[k] = en_t;
            end else begin : g_next
                assign w_ent[k] = w_carry[k-1];
            end
            presc_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) u_stage (
                .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
                .en_t(w_ent[k]), .preset(wpreset[k*W +: W]),
                .count(w_count[k*W +: W]), .carry_out(w_carry[k]));
        end
    endgenerate

    typedef struct {
        logic [W-1:0]  cnt;
        logic          cy;
        logic [WW-1:0] wcnt;
        logic          wcy;
        string         req;
    } item_t;

    item_t q[$];
    int compared   = 0;
    int mismatched = 0;
    logic [W-1:0]  m  = '0;
    logic [WW-1:0] wm = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: apply inputs at the falling edge, push the post-edge expectation.
    task automatic drive(input logic c, input logic l, input logic p, input logic t,
                         input logic [W-1:0] pre, input logic [WW-1:0] wpre,
                         input string req);
        item_t it;
        logic [W-1:0] old;
        @(negedge clk);
        clr_n = c; load_n = l; en_p = p; en_t = t; preset = pre; wpreset = wpre;
        old = m;
        if (!c) begin
            m = '0; wm = '0;
        end else if (!l) begin
            m = pre; wm = wpre;
        end else if (p && t) begin
            m = m + 1'b1; wm = wm + 1'b1;
        end
        it.cnt  = m;
        it.cy   = t && (m == '1);
        it.wcnt = wm;
        it.wcy  = t && (wm == '1);
        it.req  = req;
        q.push_back(it);
        if (!c) begin
            #1;
            check(a_count == '0, "R3 async clear before edge", int'(a_count), 0);
            check(s_count == old, "R3 sync clear waits for edge", int'(s_count), int'(old));
        end
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(a_count == it.cnt, {it.req, " async count"}, int'(a_count), int'(it.cnt));
                check(s_count == it.cnt, {it.req, " sync count"}, int'(s_count), int'(it.cnt));
                check(a_carry == it.cy, {it.req, " carry"}, int'(a_carry), int'(it.cy));
                check(s_carry == it.cy, {it.req, " sync carry"}, int'(s_carry), int'(it.cy));
                check(w_count == it.wcnt, {it.req, " chain count"}, int'(w_count), int'(it.wcnt));
                check(w_carry[STAGES-1] == it.wcy, {it.req, " chain carry"},
                      int'(w_carry[STAGES-1]), int'(it.wcy));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R3: clear from reset
        drive(0, 1, 1, 1, 4'h0, 12'h000, "R3");
        drive(0, 1, 1, 1, 4'h0, 12'h000, "R3");
        // R2: preset load
        drive(1, 0, 0, 0, 4'h5, 12'h5A5, "R2");
        // R4: counting
        repeat (3) drive(1, 1, 1, 1, 4'h0, 12'h000, "R4");
        // R8: hold with enables partly or fully low
        drive(1, 1, 0, 1, 4'h0, 12'h000, "R8");
        drive(1, 1, 1, 0, 4'h0, 12'h000, "R8");
        drive(1, 1, 0, 0, 4'h0, 12'h000, "R8");
        // R1: load beats count, clear beats load
        drive(1, 0, 1, 1, 4'hC, 12'hFFD, "R1");
        drive(0, 0, 1, 1, 4'h9, 12'h999, "R1");
        // R5/R6/R7: carry at max and wrap
        drive(1, 0, 0, 0, 4'hE, 12'hFFE, "R2");
        drive(1, 1, 1, 1, 4'h0, 12'h000, "R5");
        drive(1, 1, 0, 1, 4'h0, 12'h000, "R6");
        drive(1, 1, 0, 0, 4'h0, 12'h000, "R6");
        drive(1, 1, 1, 1, 4'h0, 12'h000, "R7");
        // R9: carry across stage boundary, then a long mixed run
        drive(1, 0, 0, 0, 4'h3, 12'h0EF, "R9");
        drive(1, 1, 1, 1, 4'h0, 12'h000, "R9");
        drive(1, 0, 0, 0, 4'hA, 12'hF0A, "R9");
        for (int i = 0; i < 300; i++) begin
            drive(1, 1, (i % 5) != 0, (i % 7) != 0, 4'h0, 12'h000, "R9");
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule